// File: doc/BRIEF.md
# Stop-Mode Wake Controller

This block decides when a halted microcontroller core comes back to life. While the core sits in its low-power stop state, the block watches the port pins. It picks one wake source through a select field. The source is a single port-3 pin, port-2 pin 7, the NOR of the low or of all port-2 bits, or, through a second register, the AND of those port-2 groups. The block compares the selected value against a programmable active level.

On an accepted wake it pulses a wake request. It then holds an internal core reset for a fixed delay, or, in fast-wake mode, skips the delay but only accepts a condition that has been stable for several clocks. A status bit tells software whether the last start was cold (power-on) or warm (after a stop). Software programs both registers before issuing the stop-entry pulse. That pulse arms the detector and parks the core's run signal.

Top module: `wake_stop_ctrl`

## Requirements
- R1: After reset, `main_o` reads 0x20 (source 000, delay enabled, active level low, warm flag 0), `aux_o` reads 0x00, `run_o`=1, `core_rst_o`=0 and `wake_o`=0. Bits 1:0 of the main register are plain read/write storage with no effect.
- R2: Main register bits 4:2 select the source, and the wake condition is "selected value equals the active level". The codes are: 000 none, 001..100 port-3 pin 0..3, 101 port-2 pin 7, 110 NOR of port-2 bits 3:0, 111 NOR of port-2 bits 7:0.
- R3: Aux register bits 1:0 select a combined source: 00 none, 01 AND of port-2 bits 3:0, 10 AND of port-2 bits 7:0, 11 none.
- R4: Main register bit 6 sets the active level: 1 wakes on a high value and 0 wakes on a low value.
- R5: With main bit 5 set, an armed detector accepts a true condition at once. A pin change driven before clock edge 1 gives `wake_o` high for exactly one cycle after edge 3, because the pins pass through two synchroniser flops. `core_rst_o` is then high for exactly DLY_CYCLES cycles (CLK_HZ/1e6*DELAY_US), `run_o` is low during that time, and `run_o` rises when `core_rst_o` falls.
- R6: With main bit 5 clear (fast wake), the condition must stay true for HOLD_CYCLES consecutive clocks. `wake_o` then pulses after edge 7 for the default of 5, and `run_o` rises with it, with no core reset. A condition that is true for fewer clocks produces no wake.
- R7: Main bit 7 is read-only. It is set by `stop_entry_i`, ignores writes, and only reset clears it.
- R8: No wake occurs unless the detector has been armed by `stop_entry_i` and `stop_i` is high. At most one wake occurs per arming. A source of none never wakes.
- R9: If both source fields are nonzero, the aux selection is used and aux bit 7, a sticky error flag cleared only by reset, is set.
- R10: `stop_entry_i` drives `run_o` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| main_we_i | input | 1 | Write strobe for main register |
| aux_we_i | input | 1 | Write strobe for aux register |
| wdata_i | input | 8 | Write data |
| main_o | output | 8 | Main register readback |
| aux_o | output | 8 | Aux register readback, bit 7 error flag |
| p3_i | input | 4 | Port-3 pins 3:0 |
| p2_i | input | 8 | Port-2 pins 7:0 |
| stop_i | input | 1 | Core is in stop mode |
| stop_entry_i | input | 1 | One-cycle pulse on stop entry |
| wake_o | output | 1 | One-cycle wake request |
| core_rst_o | output | 1 | Internal core reset during wake delay |
| run_o | output | 1 | Core run enable |

## Verification
The bench builds the block with CLK_HZ=1_000_000 and DELAY_US=16, which shrinks the multi-millisecond wake delay to 16 cycles. This lets every delayed wake be followed to its reset release inside a short window. HOLD_CYCLES stays at 5, so pulses of 4 and 5 clocks probe the exact fast-wake acceptance edge. Random register and pin patterns cover every source code and both levels, and also cover conflicting source fields.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    SRC_NONE, SRC_P3_0, SRC_P3_1, SRC_P3_2, SRC_P3_3, SRC_P2_7, SRC_NOR_LO, SRC_NOR_ALL
  } main_src_e;

  typedef enum logic [1:0] {AUX_NONE, AUX_AND_LO, AUX_AND_ALL, AUX_RSVD} aux_src_e;

  typedef struct packed {
    logic      warm;
    logic      pol;
    logic      dly_en;
    main_src_e src;
    logic [1:0] spare;
  } main_reg_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wake_src_sel.sv
module wake_src_sel
  import wake_pkg::*;
(
  input  main_src_e  main_src_i,
  input  aux_src_e   aux_src_i,
  input  logic       pol_i,
  input  logic [3:0] p3_i,
  input  logic [7:0] p2_i,
  output logic       cond_o
);
  logic val, has;

  always_comb begin
    val = 1'b0;
    has = 1'b1;
    if (aux_src_i != AUX_NONE) begin
      // aux field overrides main on conflict
      unique case (aux_src_i)
        AUX_AND_LO:  val = &p2_i[3:0];
        AUX_AND_ALL: val = &p2_i;
        default:     has = 1'b0;
      endcase
    end else begin
      unique case (main_src_i)
        SRC_P3_0:    val = p3_i[0];
        SRC_P3_1:    val = p3_i[1];
        SRC_P3_2:    val = p3_i[2];
        SRC_P3_3:    val = p3_i[3];
        SRC_P2_7:    val = p2_i[7];
        SRC_NOR_LO:  val = ~|p2_i[3:0];
        SRC_NOR_ALL: val = ~|p2_i;
        default:     has = 1'b0;
      endcase
    end
  end

  assign cond_o = has && (val == pol_i);
endmodule

// File: rtl/wake_delay.sv
module wake_delay #(
  parameter int CNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int W = $clog2(CNT + 1);

  logic [W-1:0] cnt_q;
  logic         busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= W'(CNT - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  a_r5_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !busy_o);
  a_r5_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/wake_stop_ctrl.sv
module wake_stop_ctrl
  import wake_pkg::*;
#(
  parameter int CLK_HZ      = 12_000_000,
  parameter int DELAY_US    = 5000,
  parameter int HOLD_CYCLES = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       main_we_i,
  input  logic       aux_we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] main_o,
  output logic [7:0] aux_o,
  input  logic [3:0] p3_i,
  input  logic [7:0] p2_i,
  input  logic       stop_i,
  input  logic       stop_entry_i,
  output logic       wake_o,
  output logic       core_rst_o,
  output logic       run_o
);
  localparam int DLY_CYCLES = (CLK_HZ / 1_000_000) * DELAY_US;
  localparam int HW         = $clog2(HOLD_CYCLES + 1);

  main_reg_t  main_q;
  aux_src_e   aux_q;
  logic       err_q, armed_q, wake_q, run_q;
  logic [HW-1:0] hold_q;
  logic [3:0] p3_s;
  logic [7:0] p2_s;
  logic       cond, active, accept, dly_done, dly_busy;

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '{warm: 1'b0, pol: 1'b0, dly_en: 1'b1, src: SRC_NONE, spare: 2'b00};
      aux_q  <= AUX_NONE;
      err_q  <= 1'b0;
    end else begin
      if (main_we_i) begin
        main_q.pol    <= wdata_i[6];
        main_q.dly_en <= wdata_i[5];
        main_q.src    <= main_src_e'(wdata_i[4:2]);
        main_q.spare  <= wdata_i[1:0];
      end
      if (stop_entry_i) main_q.warm <= 1'b1;
      if (aux_we_i) aux_q <= aux_src_e'(wdata_i[1:0]);
      if (main_q.src != SRC_NONE && aux_q != AUX_NONE) err_q <= 1'b1;
    end
  end

  assign main_o = main_q;
  assign aux_o  = {err_q, 5'b0, aux_q};

  wake_sync #(.W(12)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({p3_i, p2_i}),
    .q_o   ({p3_s, p2_s})
  );

  wake_src_sel i_sel (
    .main_src_i(main_q.src),
    .aux_src_i (aux_q),
    .pol_i     (main_q.pol),
    .p3_i      (p3_s),
    .p2_i      (p2_s),
    .cond_o    (cond)
  );

  assign active = armed_q && stop_i;
  assign accept = active && cond &&
                  (main_q.dly_en || hold_q == HW'(HOLD_CYCLES - 1));

  // detector and run control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      hold_q  <= '0;
      wake_q  <= 1'b0;
      run_q   <= 1'b1;
    end else begin
      wake_q <= accept;
      if (!active || !cond)                  hold_q <= '0;
      else if (hold_q != HW'(HOLD_CYCLES - 1)) hold_q <= hold_q + 1'b1;
      if (stop_entry_i) armed_q <= 1'b1;
      else if (accept)  armed_q <= 1'b0;
      if (stop_entry_i)                        run_q <= 1'b0;
      else if (accept && !main_q.dly_en)       run_q <= 1'b1;
      else if (dly_done && !accept)            run_q <= 1'b1;
    end
  end

  wake_delay #(.CNT(DLY_CYCLES)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept && main_q.dly_en),
    .busy_o (dly_busy),
    .done_o (dly_done)
  );

  assign wake_o     = wake_q;
  assign core_rst_o = dly_busy;
  assign run_o      = run_q;

  a_r7_warm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_q.warm |=> main_q.warm);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r8_wake_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(stop_i));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  a_r5_no_run_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !run_o);
  a_r10_entry_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_entry_i |=> !run_o);
endmodule

// File: tb/test_wake_stop_ctrl.sv
module test_wake_stop_ctrl;
  localparam int DLY  = 16;
  localparam int HOLD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic main_we = 0, aux_we = 0, stop = 0, stop_entry = 0;
  logic [7:0] wdata = '0, p2 = '0;
  logic [3:0] p3 = '0;
  logic [7:0] main_rd, aux_rd;
  logic wake, core_rst, run;
  int n_chk = 0, n_fail = 0;
  bit exp_err = 0, done = 0;

  always #4 clk = ~clk;

  wake_stop_ctrl #(.CLK_HZ(1_000_000), .DELAY_US(16), .HOLD_CYCLES(HOLD)) i_wake_stop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .main_we_i(main_we), .aux_we_i(aux_we), .wdata_i(wdata),
    .main_o(main_rd), .aux_o(aux_rd), .p3_i(p3), .p2_i(p2), .stop_i(stop),
    .stop_entry_i(stop_entry), .wake_o(wake), .core_rst_o(core_rst), .run_o(run));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2/R3/R4: expected wake condition
  function automatic bit cond_of(logic [2:0] ms, logic [1:0] as, bit pol,
                                 logic [3:0] q3, logic [7:0] q2);
    bit v;
    if (as != 0) begin
      if (as == 2'd1) v = &q2[3:0];
      else if (as == 2'd2) v = &q2;
      else return 0;
    end else begin
      case (ms)
        3'd0: return 0;
        3'd1, 3'd2, 3'd3, 3'd4: v = q3[ms - 1];
        3'd5: v = q2[7];
        3'd6: v = ~|q2[3:0];
        default: v = ~|q2;
      endcase
    end
    return v == pol;
  endfunction

  task automatic wr(bit is_main, logic [7:0] d);
    @(negedge clk);
    wdata = d; main_we = is_main; aux_we = !is_main;
    @(negedge clk);
    main_we = 0; aux_we = 0;
  endtask

  task automatic trial(logic [2:0] ms, logic [1:0] as, bit pol, bit dly, bit use_stop,
                       int hold, bit want_wake);
    logic [3:0] a3, b3;
    logic [7:0] a2, b2;
    int first, n_wake, n_rst;
    bit exp_wake;
    wr(1, {1'b0, pol, dly, ms, 2'b01});
    wr(0, {6'b0, as});
    if (ms != 0 && as != 0) exp_err = 1;
    do begin a3 = 4'($urandom); a2 = 8'($urandom); end while (cond_of(ms, as, pol, a3, a2));
    b3 = 4'($urandom); b2 = 8'($urandom);
    for (int t = 0; t < 60 && want_wake && !cond_of(ms, as, pol, b3, b2); t++) begin
      b3 = 4'($urandom); b2 = 8'($urandom);
    end
    @(negedge clk); p3 = a3; p2 = a2;
    repeat (4) @(negedge clk);
    chk("R9 err flag", aux_rd[7], exp_err);
    chk("R1 spare bits", main_rd[1:0], 1);
    stop_entry = 1; stop = use_stop;
    @(negedge clk); stop_entry = 0;
    chk("R10 run parked", run, 0);
    chk("R7 warm set", main_rd[7], 1);
    exp_wake = use_stop && cond_of(ms, as, pol, b3, b2) && (dly || hold == 0 || hold >= HOLD);
    first = 0; n_wake = 0; n_rst = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) begin p3 = b3; p2 = b2; end
      if (hold != 0 && k == hold + 1) begin p3 = a3; p2 = a2; end
      @(posedge clk); #1;
      if (wake) begin n_wake++; if (first == 0) first = k; end
      if (core_rst) n_rst++;
      if (core_rst && run) chk("R5 run low in reset", run, 0);
    end
    if (!exp_wake) begin
      chk(ms == 0 && as == 0 ? "R8 no source" : (use_stop ? "R6 short pulse" : "R8 no stop"),
          n_wake, 0);
      chk("R8 run stays low", run, 0);
    end else if (dly) begin
      chk("R5 wake latency", first, 3);
      chk("R5 single pulse", n_wake, 1);
      chk("R5 reset length", n_rst, DLY);
      chk("R5 run released", run, 1);
    end else begin
      chk("R6 fast latency", first, 2 + HOLD);
      chk("R6 no reset", n_rst, 0);
      chk("R6 run released", run, 1);
    end
    @(negedge clk); stop = 0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 main reset", main_rd, 8'h20);
    chk("R1 aux reset", aux_rd, 8'h00);
    chk("R1 run reset", run, 1);
    chk("R1 rst/wake reset", {core_rst, wake}, 0);
    // directed corners
    trial(3'd1, 2'd0, 1, 1, 1, 0, 1);   // R2 R4 delayed wake high level
    trial(3'd6, 2'd0, 0, 0, 1, 0, 1);   // R6 fast wake
    trial(3'd5, 2'd0, 1, 0, 1, 4, 1);   // R6 4-cycle pulse rejected
    trial(3'd5, 2'd0, 1, 0, 1, 5, 1);   // R6 5-cycle pulse accepted
    trial(3'd7, 2'd0, 0, 1, 1, 1, 1);   // R5 1-cycle pulse accepted with delay
    trial(3'd2, 2'd0, 1, 1, 0, 0, 1);   // R8 stop low
    trial(3'd0, 2'd0, 1, 1, 1, 0, 1);   // R8 no source
    trial(3'd0, 2'd1, 1, 1, 1, 0, 1);   // R3 AND low
    trial(3'd0, 2'd2, 0, 0, 1, 0, 1);   // R3 AND all, low level
    trial(3'd3, 2'd2, 1, 1, 1, 0, 1);   // R9 conflict, aux wins
    wr(1, 8'h00);
    chk("R7 bit7 ignores writes", main_rd[7], 1);
    for (int i = 0; i < 40; i++) begin
      logic [1:0] as;
      as = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      trial(3'($urandom), as, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
            ($urandom % 4 == 0) ? 1 + $urandom % 6 : 0, ($urandom % 4) != 0);
    end
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R7 cold after reset", main_rd, 8'h20);
    chk("R9 err cleared by reset", aux_rd[7], 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule